// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

A small synchronous static memory, described so that it can be synthesized, that accepts a new read or write command on every enabled clock. Reads and writes may follow each other in any order. A write-to-read or read-to-write change costs no idle cycle. Address, write enable, per-lane write selects and three chip enables are registered on the rising clock edge. A single clock enable freezes the whole block. Reads are flow-through: the word for an address registered at one edge is presented during the very next cycle.

Write data trails its address by one enabled cycle, so the data bus always carries the data of the command registered at the previous enabled edge. A captured write waits in a pending slot. It is copied into the array when the next write's data arrives. Reads that hit that slot get a per-lane merge of the slot and the array. The bidirectional pad is modelled as a separate input, output and output-enable. A level-sensitive, active-low output enable gates the drive without touching any state.

Top module: `ztsram`

## Requirements
- R1: While reset is asserted and after it is released, before any selected command has been registered, `dqOe` is 0.
- R2: A selected read (`weIn`=0) registered at an enabled edge makes `dqOe`=1 during the following cycle when `outEnN`=0. In that cycle `dqOut` is the stored word at the registered address.
- R3: A write updates only the 9-bit lanes whose `laneSel` bit is 1. Lane i is bits 9*i+8..9*i. The other lanes keep their old contents.
- R4: A read issued at the edge right after a write's data edge, to the same address, returns the newly written lanes merged with the older contents of the unwritten lanes.
- R5: Any random mix of reads and writes, one command on every enabled edge, returns data equal to a memory that applies each write at its data edge.
- R6: The block is selected only when `ce1N`=0, `ce2`=1 and `ce3N`=0. Any other combination at an enabled edge performs no write and leaves `dqOe`=0 in the next cycle.
- R7: `outEnN` acts without a clock. `outEnN`=1 forces `dqOe`=0 at once, and returning it to 0 restores the drive in the same cycle.
- R8: During the data cycle of a write, `dqOe` is 0 whatever the level of `outEnN`.
- R9: An edge with `clkEn`=0 changes no state. Inputs at that edge are ignored, and `dqOut` and the pending command are unchanged.
- R10: Write data is sampled from `dqIn` at the first enabled edge after the write's address edge, even when disabled edges lie between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control and pending state |
| clkEn | input | 1 | Clock qualifier; 0 extends the previous cycle |
| addr | input | 4 | Word address |
| weIn | input | 1 | 1 = write, 0 = read |
| laneSel | input | 4 | Per-lane write select, active high |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dqIn | input | 36 | Bus value seen at the pad (write data) |
| dqOut | output | 36 | Read data toward the pad |
| dqOe | output | 1 | Pad driver enable |

## Verification
The hardest situation to reach is a read that hits the pending slot while the slot holds a partial lane mask and the array still holds older data for that address. That needs a write, then a read to the same word with no other write between them. The directed phase builds this with explicit write/read pairs, some separated by clock-enable stalls. The random phase uses a 16-word space with a large share of writes, so that hits with mixed masks come up often. A write then a read of the same word is also checked while `outEnN` is toggled inside the data cycle.

// File: rtl/ztsram_pkg.sv
package ztsram_pkg;
  localparam int ZT_ADDR_W = 4;
  localparam int ZT_LANES  = 4;
  localparam int ZT_LANE_W = 9;

  // Strobes handed from control to datapath for the current cycle
  typedef struct packed {
    logic adv;      // this edge advances state
    logic rdValid;  // current cycle is a read data cycle
    logic wrPhase;  // current cycle is a write data cycle
  } strobe_t;
endpackage

// File: rtl/ztsram_ctrl.sv
module ztsram_ctrl
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = ZT_ADDR_W,
  parameter int LANES  = ZT_LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              weIn,
  input  logic [LANES-1:0]  laneSelIn,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [LANES-1:0]  cmdMask
);
  logic selNow;
  logic cmdValid;
  logic cmdWrite;

  assign selNow = ~ce1N & ce2 & ~ce3N;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdWrite <= 1'b0;
      cmdAddr  <= '0;
      cmdMask  <= '0;
    end else if (clkEn) begin
      cmdValid <= selNow;
      cmdWrite <= selNow & weIn;
      cmdAddr  <= addrIn;
      cmdMask  <= laneSelIn;
    end
  end

  always_comb begin
    stb.adv     = clkEn;
    stb.rdValid = cmdValid & ~cmdWrite;
    stb.wrPhase = cmdValid & cmdWrite;
  end
endmodule

// File: rtl/ztsram_dp.sv
module ztsram_dp
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = ZT_ADDR_W,
  parameter int LANES  = ZT_LANES,
  parameter int LANE_W = ZT_LANE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic [ADDR_W-1:0]         cmdAddr,
  input  logic [LANES-1:0]          cmdMask,
  input  logic [LANES*LANE_W-1:0]   dqIn,
  output logic [LANES*LANE_W-1:0]   rdData
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              pendValid;
  logic [ADDR_W-1:0] pendAddr;
  logic [LANES-1:0]  pendMask;
  logic [DATA_W-1:0] pendData;
  logic              captureWr;
  logic              pendHit;
  logic [DATA_W-1:0] arrWord;

  assign captureWr = stb.adv & stb.wrPhase;

  // Late-write slot: new write parks here, previous one retires to the array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendMask  <= '0;
      pendData  <= '0;
    end else if (captureWr) begin
      pendValid <= 1'b1;
      pendAddr  <= cmdAddr;
      pendMask  <= cmdMask;
      pendData  <= dqIn;
    end
  end

  always_ff @(posedge clk) begin
    if (captureWr && pendValid) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendMask[l]) mem[pendAddr][l*LANE_W +: LANE_W] <= pendData[l*LANE_W +: LANE_W];
      end
    end
  end

  assign arrWord = mem[cmdAddr];
  assign pendHit = pendValid && (pendAddr == cmdAddr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rdData[g*LANE_W +: LANE_W] = (pendHit && pendMask[g])
                                        ? pendData[g*LANE_W +: LANE_W]
                                        : arrWord[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ztsram.sv
module ztsram
  import ztsram_pkg::*;
#(
  parameter int ADDR_W = ZT_ADDR_W,
  parameter int LANES  = ZT_LANES,
  parameter int LANE_W = ZT_LANE_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    weIn,
  input  logic [LANES-1:0]        laneSel,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    outEnN,
  input  logic [LANES*LANE_W-1:0] dqIn,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqOe
);
  strobe_t           stb;
  logic [ADDR_W-1:0] cmdAddr;
  logic [LANES-1:0]  cmdMask;

  ztsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addrIn(addr), .weIn(weIn),
    .laneSelIn(laneSel), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .stb(stb), .cmdAddr(cmdAddr), .cmdMask(cmdMask)
  );

  ztsram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdAddr(cmdAddr), .cmdMask(cmdMask),
    .dqIn(dqIn), .rdData(dqOut)
  );

  // Drivers on only in a read data cycle, gated level-sensitively by outEnN
  assign dqOe = stb.rdValid & ~outEnN;
endmodule

// File: rtl/ztsram_chk.sv
module ztsram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              weIn,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              outEnN,
  input logic              dqOe,
  input logic [DATA_W-1:0] dqOut,
  input logic              wrPhase
);
  logic selSeen;
  assign selSeen = ~ce1N & ce2 & ~ce3N;

  // R2: a registered read drives the bus next cycle unless outEnN is high
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && selSeen && !weIn) |=> (dqOe == !outEnN));

  // R6: a deselect edge leaves the bus undriven in the following cycle
  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !selSeen) |=> !dqOe);

  // R7: outEnN high never lets the bus be driven
  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dqOe);

  // R8: no drive in the data cycle of a write
  assert_write_phase_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrPhase |-> !dqOe);

  // R9: a disabled edge keeps the read data unchanged
  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(dqOut));
endmodule

bind ztsram ztsram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .weIn(weIn), .ce1N(ce1N), .ce2(ce2),
  .ce3N(ce3N), .outEnN(outEnN), .dqOe(dqOe), .dqOut(dqOut), .wrPhase(stb.wrPhase)
);

// File: tb/ztsram_bench.sv
module ztsram_bench;
  localparam int AW = 4;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1;
  logic [AW-1:0] addr = '0;
  logic weIn = 1'b0;
  logic [NL-1:0] laneSel = '0;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic outEnN = 1'b0;
  logic [DW-1:0] dqIn = '0;
  logic [DW-1:0] dqOut;
  logic dqOe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] refMem [1<<AW];
  bit curValid = 0, curWrite = 0;
  logic [AW-1:0] curAddr = '0;
  logic [NL-1:0] curMask = '0;

  always #5 clk = ~clk;

  ztsram u_ztsram (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .addr(addr), .weIn(weIn),
    .laneSel(laneSel), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N), .outEnN(outEnN),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  function automatic logic [DW-1:0] mergeLanes(logic [DW-1:0] oldW, logic [DW-1:0] newW, logic [NL-1:0] m);
    logic [DW-1:0] r = oldW;
    for (int l = 0; l < NL; l++) if (m[l]) r[l*LW +: LW] = newW[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd36();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string tag);
    bit expOe = curValid && !curWrite && !outEnN;
    string oeTag = curWrite ? "R8" : (!curValid ? "R6" : tag);
    check(dqOe == expOe, oeTag, DW'(dqOe), DW'(expOe));
    if (expOe) check(dqOut == refMem[curAddr], tag, dqOut, refMem[curAddr]);
  endtask

  // One cycle: ceBits = {ce1N, ce2, ce3N}; 3'b010 selects
  task automatic step(input logic [2:0] ceBits, input logic we, input logic [AW-1:0] a,
                      input logic [NL-1:0] lanes, input logic en, input logic oeN,
                      input bit probeOe, input string tag);
    @(negedge clk);
    {ce1N, ce2, ce3N} = ceBits;
    weIn = we; addr = a; laneSel = lanes; clkEn = en; outEnN = oeN;
    dqIn = rnd36();
    #1;
    checkOutputs(tag);
    if (probeOe) begin
      // R7: output enable acts without a clock edge
      outEnN = 1'b1; #1;
      check(dqOe == 1'b0, "R7", DW'(dqOe), '0);
      outEnN = 1'b0; #1;
      check(dqOe == (curValid && !curWrite), "R7", DW'(dqOe), DW'(curValid && !curWrite));
      outEnN = oeN; #1;
    end
    @(posedge clk);
    if (en) begin
      if (curValid && curWrite) refMem[curAddr] = mergeLanes(refMem[curAddr], dqIn, curMask);
      curValid = (ceBits == 3'b010);
      curWrite = (ceBits == 3'b010) && we;
      curAddr  = a;
      curMask  = lanes;
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] m, input string tag);
    step(3'b010, 1'b1, a, m, 1'b1, 1'b0, 0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(3'b010, 1'b0, a, '0, 1'b1, 1'b0, 0, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4855));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(dqOe == 1'b0, "R1", DW'(dqOe), '0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(dqOe == 1'b0, "R1", DW'(dqOe), '0);

    // fill the array with full-lane writes
    for (int i = 0; i < (1<<AW); i++) wr(AW'(i), '1, "R5");
    rd(AW'(0), "R2");
    for (int i = 0; i < (1<<AW); i++) rd(AW'(i), "R2");

    // R3/R4: partial write followed at once by a read to the same word
    wr(4'd3, 4'b0101, "R3");
    rd(4'd3, "R4");       // data cycle of the write
    rd(4'd3, "R4");       // read hits pending slot
    wr(4'd3, 4'b1000, "R3");
    wr(4'd7, 4'b0010, "R3");  // retires earlier slot to array
    rd(4'd3, "R4");
    rd(4'd7, "R4");
    rd(4'd3, "R3");
    wr(4'd9, 4'b0000, "R3");  // no lane selected
    rd(4'd9, "R3");
    rd(4'd9, "R3");

    // R6: each chip enable inactive alone, plus writes while deselected
    step(3'b110, 1'b1, 4'd5, '1, 1'b1, 1'b0, 0, "R6");
    step(3'b000, 1'b1, 4'd5, '1, 1'b1, 1'b0, 0, "R6");
    step(3'b011, 1'b1, 4'd5, '1, 1'b1, 1'b0, 0, "R6");
    rd(4'd5, "R6");
    rd(4'd5, "R6");

    // R9/R10: stalls between write address and its data
    wr(4'd12, 4'b1111, "R10");
    step(3'b010, 1'b1, 4'd1, '1, 1'b0, 1'b0, 0, "R9");
    step(3'b101, 1'b0, 4'd2, '1, 1'b0, 1'b0, 0, "R9");
    rd(4'd12, "R10");
    step(3'b010, 1'b1, 4'd12, '1, 1'b0, 1'b0, 0, "R9");
    step(3'b010, 1'b1, 4'd12, '1, 1'b0, 1'b0, 0, "R9");
    rd(4'd1, "R9");
    rd(4'd2, "R9");

    // R8 with outEnN low, R7 probing inside a read cycle
    wr(4'd6, 4'b0110, "R8");
    step(3'b010, 1'b0, 4'd6, '0, 1'b1, 1'b0, 0, "R8");
    step(3'b010, 1'b0, 4'd6, '0, 1'b1, 1'b0, 1, "R7");
    step(3'b110, 1'b0, 4'd6, '0, 1'b1, 1'b1, 0, "R7");

    // R5: random mix, every edge a command
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ceB = ($urandom_range(0, 9) == 0) ? 3'($urandom) : 3'b010;
      step(ceB, 1'($urandom_range(0, 1)), AW'($urandom), NL'($urandom),
           ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 15) == 0), "R5");
    end
    finishRun();
  end
endmodule